// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the instruction cache in the fetch stage and chooses the next fetch address. The current fetch PC goes into a direct-mapped table in the same cycle that it goes to instruction memory. On a hit, the instruction is taken to be a branch that is predicted taken, and the stored target becomes the next fetch PC. On a miss, fetch moves on to the sequential address, which is the fetch PC plus 4.

The table holds only branches that are predicted taken. The execute stage reports each resolved branch to the block. The report carries the branch PC, the actual direction, the actual target, and whether the lookup hit when that branch was fetched.

- A branch that missed and resolves as taken gets an entry.
- A branch that hit and resolves as not taken loses its entry.
- In both of those cases, the block pulses a flush in the next cycle and gives the PC at which fetch restarts.
- A correct prediction changes nothing.

Top module: `fetch_target_buf`

## Requirements
- R1: After an active-low reset, every entry is invalid, so every lookup misses, and `flush_o` is low.
- R2: A lookup hits when the entry at index bits [5:2] of the fetch PC is valid and its stored tag equals bits [31:6]. On a hit, `pred_hit_o` is 1 and `next_pc_o` equals the stored target, both in the same cycle.
- R3: On a miss, `pred_hit_o` is 0 and `next_pc_o` equals the fetch PC plus 4. This includes a valid entry at the same index whose tag differs.
- R4: A resolve with valid=1, hit=0 and taken=1 writes the branch's tag and actual target into its index, replacing any previous occupant. From the next cycle on, a lookup of that PC hits and returns that target.
- R5: The resolve case in R4 sets `flush_o` high in the next cycle, with `restart_pc_o` equal to the actual target.
- R6: A resolve with valid=1, hit=1 and taken=0 invalidates the entry at its index if the stored tag matches. In the next cycle it sets `flush_o` high, with `restart_pc_o` equal to the branch PC plus 4.
- R7: A resolve with hit=1 and taken=1, or with hit=0 and taken=0, leaves the table unchanged and raises no flush.
- R8: When a lookup and an update touch the same index in one cycle, the lookup returns the contents as they were before the update.
- R9: A delete request whose tag does not match the stored tag leaves that entry valid, and the entry keeps its target.
- R10: `flush_o` is high for exactly the one cycle after each mispredicting resolve. It is low in any cycle that does not follow a resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | 32 | Current fetch PC |
| pred_hit_o | output | 1 | The lookup hit, so the branch is predicted taken |
| next_pc_o | output | 32 | Next fetch PC |
| rs_valid_i | input | 1 | A resolved branch is reported this cycle |
| rs_pc_i | input | 32 | PC of the resolved branch |
| rs_taken_i | input | 1 | Actual direction (1 means taken) |
| rs_target_i | input | 32 | Actual taken target |
| rs_hit_i | input | 1 | The branch hit the table when it was fetched |
| flush_o | output | 1 | Kill the wrongly fetched path and restart fetch |
| restart_pc_o | output | 32 | PC at which fetch restarts |

## Verification
Directed cases separate three situations that look alike at a single index:

- a stored branch from an alias with another tag at the same index (R3);
- a delete whose tag matches from one whose tag does not (R9);
- a lookup in the same cycle as an update from a lookup one cycle later (R8).

Randomly drawn PCs come from two tags over all sixteen indices, so allocation, replacement, deletion and aliasing all recur often. The resolve hit flag usually follows the bench's own table, but sometimes it contradicts that table. This shows that the flush and the table changes follow the reported hit flag, and that deletion is still guarded by the stored tag.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_ALLOC  = 2'd1,
    ACT_DELETE = 2'd2
  } rs_act_e;
endpackage

// File: rtl/btb_resolve_ctrl.sv
module btb_resolve_ctrl
  import btb_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rs_valid_i,
  input  logic [PC_W-1:0] rs_pc_i,
  input  logic            rs_taken_i,
  input  logic [PC_W-1:0] rs_target_i,
  input  logic            rs_hit_i,
  output rs_act_e         act_o,
  output logic            flush_o,
  output logic [PC_W-1:0] restart_pc_o
);
  localparam logic [PC_W-1:0] INC = PC_W'(4);

  always_comb begin
    act_o = ACT_NONE;
    if (rs_valid_i) begin
      if (!rs_hit_i && rs_taken_i) act_o = ACT_ALLOC;
      else if (rs_hit_i && !rs_taken_i) act_o = ACT_DELETE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_o      <= 1'b0;
      restart_pc_o <= '0;
    end else begin
      flush_o <= rs_valid_i && (rs_hit_i != rs_taken_i);
      if (rs_valid_i)
        restart_pc_o <= rs_taken_i ? rs_target_i : rs_pc_i + INC;
    end
  end
endmodule

// File: rtl/btb_entry_array.sv
module btb_entry_array
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int ALIGN   = 2,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = PC_W - IDX_W - ALIGN
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  output logic [PC_W-1:0]  lk_target_o,
  input  rs_act_e          wr_act_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [PC_W-1:0]  wr_target_i
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  // delete only clears the entry owned by the reporting branch
  logic del_match;
  assign del_match = (tag_q[wr_idx_i] == wr_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (wr_act_i == ACT_ALLOC) begin
      valid_q[wr_idx_i] <= 1'b1;
    end else if (wr_act_i == ACT_DELETE && del_match) begin
      valid_q[wr_idx_i] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_act_i == ACT_ALLOC) begin
      tag_q[wr_idx_i] <= wr_tag_i;
      tgt_q[wr_idx_i] <= wr_target_i;
    end
  end

  assign lk_hit_o    = valid_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);
  assign lk_target_o = tgt_q[lk_idx_i];
endmodule

// File: rtl/fetch_target_buf.sv
module fetch_target_buf
  import btb_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int ALIGN   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic [PC_W-1:0] next_pc_o,
  input  logic            rs_valid_i,
  input  logic [PC_W-1:0] rs_pc_i,
  input  logic            rs_taken_i,
  input  logic [PC_W-1:0] rs_target_i,
  input  logic            rs_hit_i,
  output logic            flush_o,
  output logic [PC_W-1:0] restart_pc_o
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - IDX_W - ALIGN;
  localparam logic [PC_W-1:0] INC = PC_W'(4);

  rs_act_e         act;
  logic [PC_W-1:0] lk_target;

  btb_resolve_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rs_valid_i   (rs_valid_i),
    .rs_pc_i      (rs_pc_i),
    .rs_taken_i   (rs_taken_i),
    .rs_target_i  (rs_target_i),
    .rs_hit_i     (rs_hit_i),
    .act_o        (act),
    .flush_o      (flush_o),
    .restart_pc_o (restart_pc_o)
  );

  btb_entry_array #(.PC_W(PC_W), .ENTRIES(ENTRIES), .ALIGN(ALIGN)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (fetch_pc_i[ALIGN +: IDX_W]),
    .lk_tag_i    (fetch_pc_i[PC_W-1 -: TAG_W]),
    .lk_hit_o    (pred_hit_o),
    .lk_target_o (lk_target),
    .wr_act_i    (act),
    .wr_idx_i    (rs_pc_i[ALIGN +: IDX_W]),
    .wr_tag_i    (rs_pc_i[PC_W-1 -: TAG_W]),
    .wr_target_i (rs_target_i)
  );

  assign next_pc_o = pred_hit_o ? lk_target : fetch_pc_i + INC;
endmodule

// File: rtl/fetch_target_buf_chk.sv
module fetch_target_buf_chk #(
  parameter int PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] fetch_pc_i,
  input logic            pred_hit_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic            rs_valid_i,
  input logic [PC_W-1:0] rs_pc_i,
  input logic            rs_taken_i,
  input logic [PC_W-1:0] rs_target_i,
  input logic            rs_hit_i,
  input logic            flush_o,
  input logic [PC_W-1:0] restart_pc_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  AST_MISS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> next_pc_o == fetch_pc_i + PC_W'(4)); // R3

  AST_ALLOC_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_i && !rs_hit_i && rs_taken_i) |=> flush_o && restart_pc_o == $past(rs_target_i)); // R5

  AST_DEL_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rs_valid_i && rs_hit_i && !rs_taken_i) |=> flush_o && restart_pc_o == $past(rs_pc_i) + PC_W'(4)); // R6

  AST_NO_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rs_valid_i || rs_hit_i == rs_taken_i) |=> !flush_o); // R10

  AST_ALLOC_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(rs_valid_i && !rs_hit_i && rs_taken_i) && fetch_pc_i == $past(rs_pc_i))
      |-> pred_hit_o && next_pc_o == $past(rs_target_i)); // R4

  AST_DEL_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(rs_valid_i && rs_hit_i && !rs_taken_i) && fetch_pc_i == $past(rs_pc_i))
      |-> !pred_hit_o); // R6
endmodule

bind fetch_target_buf fetch_target_buf_chk #(.PC_W(PC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc_i), .pred_hit_o(pred_hit_o),
  .next_pc_o(next_pc_o), .rs_valid_i(rs_valid_i), .rs_pc_i(rs_pc_i),
  .rs_taken_i(rs_taken_i), .rs_target_i(rs_target_i), .rs_hit_i(rs_hit_i),
  .flush_o(flush_o), .restart_pc_o(restart_pc_o)
);

// File: tb/fetch_target_buf_bench.sv
module fetch_target_buf_bench;
  localparam int N = 16;
  localparam logic [25:0] TAG_A = 26'h0001234;
  localparam logic [25:0] TAG_B = 26'h2000055;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_hit;
  logic [31:0] next_pc;
  logic        rs_valid = 1'b0;
  logic [31:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic [31:0] rs_target = '0;
  logic        rs_hit = 1'b0;
  logic        flush;
  logic [31:0] restart_pc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  bit          m_valid [N];
  logic [25:0] m_tag   [N];
  logic [31:0] m_tgt   [N];

  always #10 clk = ~clk;

  fetch_target_buf u_fetch_target_buf (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc), .pred_hit_o(pred_hit),
    .next_pc_o(next_pc), .rs_valid_i(rs_valid), .rs_pc_i(rs_pc), .rs_taken_i(rs_taken),
    .rs_target_i(rs_target), .rs_hit_i(rs_hit), .flush_o(flush), .restart_pc_o(restart_pc)
  );

  function automatic bit exp_hit(logic [31:0] pc);
    return m_valid[pc[5:2]] && m_tag[pc[5:2]] == pc[31:6];
  endfunction

  function automatic logic [31:0] exp_next(logic [31:0] pc);
    return exp_hit(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
  endfunction

  function automatic logic [31:0] mk_pc(bit tb, logic [3:0] idx);
    return {tb ? TAG_B : TAG_A, idx, 2'b00};
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(logic [31:0] fpc, bit rv, logic [31:0] rpc, bit rt,
                      logic [31:0] rtgt, bit rh, string rq_lk, string rq_fl);
    bit e_hit, e_fl;
    logic [31:0] e_next, e_rst;
    @(negedge clk);
    fetch_pc = fpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt;
    rs_target = rtgt; rs_hit = rh;
    #2;
    e_hit  = exp_hit(fpc);
    e_next = exp_next(fpc);
    chk(pred_hit == e_hit, rq_lk, {31'd0, pred_hit}, {31'd0, e_hit});
    chk(next_pc == e_next, rq_lk, next_pc, e_next);
    e_fl  = rv && (rh != rt);
    e_rst = rt ? rtgt : rpc + 32'd4;
    @(posedge clk);
    if (rv && !rh && rt) begin
      m_valid[rpc[5:2]] = 1'b1; m_tag[rpc[5:2]] = rpc[31:6]; m_tgt[rpc[5:2]] = rtgt;
    end else if (rv && rh && !rt && m_tag[rpc[5:2]] == rpc[31:6]) begin
      m_valid[rpc[5:2]] = 1'b0;
    end
    #2;
    chk(flush == e_fl, rq_fl, {31'd0, flush}, {31'd0, e_fl});
    if (e_fl) chk(restart_pc == e_rst, rq_fl, restart_pc, e_rst);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a3, b3, a5, t1;
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
    end
    void'($urandom(32'd581));
    a3 = mk_pc(0, 4'd3); b3 = mk_pc(1, 4'd3); a5 = mk_pc(0, 4'd5);
    t1 = 32'h0040_1000;
    #25;
    chk(flush == 1'b0, "R1", {31'd0, flush}, 32'd0);
    rst_n = 1'b1;
    step(a3, 0, '0, 0, '0, 0, "R1", "R10");
    step(a3, 1, a3, 1, t1, 0, "R8", "R5");      // same-cycle alloc: old contents
    step(a3, 0, '0, 0, '0, 0, "R4", "R10");
    step(b3, 0, '0, 0, '0, 0, "R3", "R10");     // alias with other tag
    step(a3, 1, b3, 0, '0, 1, "R2", "R6");      // delete with mismatched tag
    step(a3, 1, a3, 1, t1, 1, "R9", "R7");      // entry kept; correct hit
    step(a5, 1, a5, 0, '0, 0, "R2", "R7");      // miss not-taken, no change
    step(a5, 0, '0, 0, '0, 0, "R7", "R10");
    step(a3, 1, a3, 0, '0, 1, "R8", "R6");      // same-cycle delete: still hits
    step(a3, 0, '0, 0, '0, 0, "R6", "R10");
    step(b3, 1, b3, 1, 32'h0000_2000, 0, "R3", "R5");
    step(b3, 0, '0, 0, '0, 0, "R4", "R10");
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] fpc, rpc, tgt;
      bit rv, rt, rh;
      fpc = mk_pc($urandom_range(0, 1), 4'($urandom_range(0, 15)));
      rpc = mk_pc($urandom_range(0, 1), 4'($urandom_range(0, 15)));
      tgt = {$urandom, 2'b00} ^ 32'h0;
      tgt[1:0] = 2'b00;
      rv  = $urandom_range(0, 3) != 0;
      rt  = $urandom_range(0, 1);
      rh  = ($urandom_range(0, 9) < 8) ? exp_hit(rpc) : 1'($urandom_range(0, 1));
      step(fpc, rv, rpc, rt, tgt, rh, "R2 R3 R4 R9", "R5 R6 R7");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule